// File: doc/BRIEF.md
# PHY Receiver Bring-Up Sequencer

This block starts a multi-lane PHY receiver from a single start pulse. With the start pulse it takes two values: the number of lanes to enable and the line data rate in Mbps.

It first checks both values. It then sets the receiver's static control fields and enables the requested lanes. Next it gives the PHY's test port a timed clear pulse, with a wait on each side. Finally it runs a fixed list of register writes over the test port. The rate is turned into a range code, and that code is written into each data lane's receive-control register.

A rate above the top of the range table, or a lane count outside the supported range, ends the attempt at once with an error pulse. In that case nothing is driven. A stop input abandons a sequence at any point and switches the lanes off.

The test-port protocol has two edges. The register address is taken on the falling edge of the test clock while the enable is high. The register value is taken on the rising edge. Every step of this waveform is held for `STEP_HOLD` system clocks. The clear interval is `CLR_WAIT` clocks.

Range table, first entry whose upper bound (Mbps) is at or above the rate wins, shown as bound:code in hex:
89:00, 99:10, 109:20, 129:01, 139:11, 149:21, 169:02, 179:12, 199:22, 219:03, 239:13, 249:23, 269:04, 299:14, 329:05, 359:15, 399:25, 449:06, 499:16, 549:07, 599:17, 649:08, 699:18, 749:09, 799:19, 849:29, 899:39, 949:0a, 999:1a, 1049:2a, 1099:3a, 1149:0b, 1199:1b, 1249:2b, 1299:3b, 1349:0c, 1399:1c, 1449:2c, 1500:3c.

Top module: `rxphy_bringup_seq`

## Requirements
- R1: One cycle after an accepted start, `busy_o` is 1, `force_rx_o`, `force_stop_o` and `turn_req_o` are all zero, and `turn_dis_o` is all ones. These values hold for as long as `busy_o` is high.
- R2: On acceptance, `lane_en_o` becomes a mask of ones in its low `lane_cnt_i` bits. For example, 1 lane gives 4'b0001, 3 lanes give 4'b0111 and 4 lanes give 4'b1111.
- R3: `tp_clk_o` is already 1 when `tp_clr_o` rises. `tp_clr_o` stays high for exactly `CLR_WAIT` cycles. The first test-clock fall comes `CLR_WAIT + 1 + 2*STEP_HOLD` cycles after `tp_clr_o` falls.
- R4: Each write follows this order of steps: address on `tp_din_o`, enable high, clock low, enable low, value on `tp_din_o`, clock high. Each step lasts `STEP_HOLD` cycles. `tp_en_o` is 1 at every test-clock fall, and the fall-to-rise distance is `3*STEP_HOLD` cycles.
- R5: Seven writes are made, as address→value: 0x34→0, then 0x44, 0x54, 0x84 and 0x94 each →(range<<1), then 0x75→0x04, and last 0x00→0.
- R6: The range code is the code of the first entry in the range table whose upper bound is greater than or equal to `rate_mbps_i`. Examples: 89→0x00, 90→0x10, 129→0x01, 1500→0x3c.
- R7: A start with a rate above 1500, or with a lane count of 0 or above `NLANES`, gives `error_o`=1 for one cycle, one cycle later. `busy_o` stays 0, `lane_en_o` is unchanged, and no clear pulse or test-port write takes place.
- R8: `done_o` pulses for one cycle after the seventh write, in the same cycle in which `busy_o` drops. `done_o` never coincides with `busy_o` or `error_o`.
- R9: One cycle after `stop_i`, `busy_o`, `lane_en_o` and `tp_clr_o` are 0. No further test-port write completes and no `done_o` follows.
- R10: A start while `busy_o` is high has no effect. The lane mask and the writes of the running sequence are kept, and no error is raised.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| stop_i | input | 1 | Abort and switch lanes off |
| lane_cnt_i | input | $clog2(NLANES+1) | Requested number of lanes |
| rate_mbps_i | input | RATE_W | Line data rate in Mbps |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | One-cycle rejection pulse |
| lane_en_o | output | NLANES | Lane enable mask |
| force_rx_o | output | NLANES | Force-receive controls |
| force_stop_o | output | NLANES | Force-stop controls |
| turn_req_o | output | NLANES | Turnaround request controls |
| turn_dis_o | output | NLANES | Turnaround disable controls |
| tp_clk_o | output | 1 | Test-port clock |
| tp_clr_o | output | 1 | Test-port clear |
| tp_en_o | output | 1 | Test-port enable |
| tp_din_o | output | 8 | Test-port address/value bus |

## Verification
The bench aims at the edges of the range table: 89/90, 129 and 1500/1501. An off-by-one comparison at any of these gives the wrong code in the four lane writes, or accepts a rate that must be rejected.

It rebuilds every write from the waveform edges. A wrong step order, a missing enable at the clock fall, or a shortened hold changes the captured address or the measured edge distance.

It fires a second start in the middle of a sequence, and a stop in the middle of a write. A design that restarts on a busy start corrupts the lane mask or the write list. One that ignores the stop goes on to finish with a done pulse.

Lane counts of 0 and 5 check that the mask logic cannot enable nothing, or wrap around.

// File: rtl/rxseq_pkg.sv
package rxseq_pkg;

    localparam int TP_W          = 8;
    localparam int RANGE_W       = 6;
    localparam int RANGE_ENTRIES = 39;
    localparam int WR_COUNT      = 7;
    localparam int BOUND_W       = 11;

    // Ordered range table: the first upper bound at or above the rate selects the code.
    localparam logic [BOUND_W-1:0] RANGE_UPPER [RANGE_ENTRIES] = '{
        11'd89,   11'd99,   11'd109,  11'd129,  11'd139,  11'd149,  11'd169,  11'd179,
        11'd199,  11'd219,  11'd239,  11'd249,  11'd269,  11'd299,  11'd329,  11'd359,
        11'd399,  11'd449,  11'd499,  11'd549,  11'd599,  11'd649,  11'd699,  11'd749,
        11'd799,  11'd849,  11'd899,  11'd949,  11'd999,  11'd1049, 11'd1099, 11'd1149,
        11'd1199, 11'd1249, 11'd1299, 11'd1349, 11'd1399, 11'd1449, 11'd1500
    };

    localparam logic [RANGE_W-1:0] RANGE_CODE [RANGE_ENTRIES] = '{
        6'h00, 6'h10, 6'h20, 6'h01, 6'h11, 6'h21, 6'h02, 6'h12,
        6'h22, 6'h03, 6'h13, 6'h23, 6'h04, 6'h14, 6'h05, 6'h15,
        6'h25, 6'h06, 6'h16, 6'h07, 6'h17, 6'h08, 6'h18, 6'h09,
        6'h19, 6'h29, 6'h39, 6'h0a, 6'h1a, 6'h2a, 6'h3a, 6'h0b,
        6'h1b, 6'h2b, 6'h3b, 6'h0c, 6'h1c, 6'h2c, 6'h3c
    };

    localparam int MAX_RATE = 1500;

    localparam logic [TP_W-1:0] SETTLE_VAL = 8'h04;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_CLR_HI,
        ST_CLR_LO,
        ST_WRITE,
        ST_WAIT
    } seq_state_e;

    // Register address of each write, in issue order.
    function automatic logic [TP_W-1:0] wr_addr(input logic [2:0] idx);
        case (idx)
            3'd0:    return 8'h34;
            3'd1:    return 8'h44;
            3'd2:    return 8'h54;
            3'd3:    return 8'h84;
            3'd4:    return 8'h94;
            3'd5:    return 8'h75;
            default: return 8'h00;
        endcase
    endfunction

    // Value of each write; the lane registers carry the range code shifted by one.
    function automatic logic [TP_W-1:0] wr_value(input logic [2:0] idx,
                                                 input logic [RANGE_W-1:0] rng);
        case (idx)
            3'd1, 3'd2, 3'd3, 3'd4: return {1'b0, rng, 1'b0};
            3'd5:                   return SETTLE_VAL;
            default:                return '0;
        endcase
    endfunction

endpackage

// File: rtl/rxseq_rate_map.sv
module rxseq_rate_map
    import rxseq_pkg::*;
#(
    parameter int RATE_W = 11
) (
    input  logic [RATE_W-1:0]  rate_i,
    output logic [RANGE_W-1:0] code_o,
    output logic               hit_o
);

    // Walk from the top entry down so the lowest matching bound wins.
    always_comb begin
        code_o = '0;
        hit_o  = 1'b0;
        for (int i = RANGE_ENTRIES - 1; i >= 0; i--) begin
            if (32'(rate_i) <= 32'(RANGE_UPPER[i])) begin
                code_o = RANGE_CODE[i];
                hit_o  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rxseq_lane_mask.sv
module rxseq_lane_mask #(
    parameter int NLANES = 4,
    localparam int LCW   = $clog2(NLANES + 1)
) (
    input  logic [LCW-1:0]    cnt_i,
    output logic [NLANES-1:0] mask_o,
    output logic              ok_o
);

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        assign mask_o[g] = (32'(cnt_i) > g);
    end

    assign ok_o = (cnt_i != '0) && (32'(cnt_i) <= NLANES);

endmodule

// File: rtl/rxseq_tport.sv
module rxseq_tport
    import rxseq_pkg::*;
#(
    parameter int STEP_HOLD = 4,
    localparam int HW       = $clog2(STEP_HOLD + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            prime_i,
    input  logic            abort_i,
    input  logic            go_i,
    input  logic [TP_W-1:0] addr_i,
    input  logic [TP_W-1:0] value_i,
    output logic            tp_clk_o,
    output logic            tp_en_o,
    output logic [TP_W-1:0] tp_din_o,
    output logic            done_o
);

    localparam logic [HW-1:0] HOLD_LAST = HW'(STEP_HOLD - 1);
    localparam logic [2:0]    LAST_STEP = 3'd5;

    typedef struct packed {
        logic            active;
        logic [2:0]      step;
        logic [HW-1:0]   cnt;
        logic            tclk;
        logic            ten;
        logic [TP_W-1:0] din;
        logic [TP_W-1:0] value;
        logic            done;
    } tp_regs_t;

    tp_regs_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (abort_i) begin
            d.active = 1'b0;
            d.ten    = 1'b0;
        end else if (prime_i) begin
            d.tclk = 1'b1;
        end else if (go_i && !q.active) begin
            d.active = 1'b1;
            d.step   = '0;
            d.cnt    = '0;
            d.din    = addr_i;
            d.value  = value_i;
        end else if (q.active) begin
            if (q.cnt == HOLD_LAST) begin
                d.cnt = '0;
                if (q.step == LAST_STEP) begin
                    d.active = 1'b0;
                    d.done   = 1'b1;
                end else begin
                    d.step = q.step + 3'd1;
                    case (q.step + 3'd1)
                        3'd1:    d.ten  = 1'b1;
                        3'd2:    d.tclk = 1'b0;
                        3'd3:    d.ten  = 1'b0;
                        3'd4:    d.din  = q.value;
                        default: d.tclk = 1'b1;
                    endcase
                end
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tp_clk_o = q.tclk;
    assign tp_en_o  = q.ten;
    assign tp_din_o = q.din;
    assign done_o   = q.done;

endmodule

// File: rtl/rxphy_bringup_seq.sv
module rxphy_bringup_seq
    import rxseq_pkg::*;
#(
    parameter int NLANES    = 4,
    parameter int RATE_W    = 11,
    parameter int CLR_WAIT  = 20000,
    parameter int STEP_HOLD = 4,
    localparam int LCW      = $clog2(NLANES + 1),
    localparam int CLW      = $clog2(CLR_WAIT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [LCW-1:0]    lane_cnt_i,
    input  logic [RATE_W-1:0] rate_mbps_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              error_o,
    output logic [NLANES-1:0] lane_en_o,
    output logic [NLANES-1:0] force_rx_o,
    output logic [NLANES-1:0] force_stop_o,
    output logic [NLANES-1:0] turn_req_o,
    output logic [NLANES-1:0] turn_dis_o,
    output logic              tp_clk_o,
    output logic              tp_clr_o,
    output logic              tp_en_o,
    output logic [TP_W-1:0]   tp_din_o
);

    localparam logic [CLW-1:0] CLR_LAST = CLW'(CLR_WAIT - 1);
    localparam logic [2:0]     WR_LAST  = 3'(WR_COUNT - 1);

    typedef struct packed {
        seq_state_e         state;
        logic [CLW-1:0]     cnt;
        logic [2:0]         idx;
        logic [RANGE_W-1:0] rng;
        logic               busy;
        logic               done;
        logic               err;
        logic               clr;
        logic [NLANES-1:0]  lane_en;
        logic [NLANES-1:0]  turn_dis;
    } seq_regs_t;

    seq_regs_t d, q;

    logic [RANGE_W-1:0] rate_code;
    logic               rate_hit;
    logic [NLANES-1:0]  lane_mask;
    logic               lane_ok;
    logic               wr_go, wr_done, tp_prime, tp_abort;
    logic [TP_W-1:0]    wr_a, wr_v;

    rxseq_rate_map #(.RATE_W(RATE_W)) u_rate (
        .rate_i (rate_mbps_i),
        .code_o (rate_code),
        .hit_o  (rate_hit)
    );

    rxseq_lane_mask #(.NLANES(NLANES)) u_mask (
        .cnt_i  (lane_cnt_i),
        .mask_o (lane_mask),
        .ok_o   (lane_ok)
    );

    rxseq_tport #(.STEP_HOLD(STEP_HOLD)) u_tport (
        .clk      (clk),
        .rst_n    (rst_n),
        .prime_i  (tp_prime),
        .abort_i  (tp_abort),
        .go_i     (wr_go),
        .addr_i   (wr_a),
        .value_i  (wr_v),
        .tp_clk_o (tp_clk_o),
        .tp_en_o  (tp_en_o),
        .tp_din_o (tp_din_o),
        .done_o   (wr_done)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.err    = 1'b0;
        wr_go    = 1'b0;
        tp_prime = 1'b0;
        tp_abort = 1'b0;
        wr_a     = wr_addr(q.idx);
        wr_v     = wr_value(q.idx, q.rng);
        if (stop_i) begin
            tp_abort  = 1'b1;
            d.state   = ST_IDLE;
            d.busy    = 1'b0;
            d.clr     = 1'b0;
            d.lane_en = '0;
        end else begin
            case (q.state)
                ST_IDLE: begin
                    if (start_i) begin
                        if (rate_hit && lane_ok) begin
                            tp_prime   = 1'b1;
                            d.state    = ST_SETUP;
                            d.busy     = 1'b1;
                            d.rng      = rate_code;
                            d.lane_en  = lane_mask;
                            d.turn_dis = '1;
                            d.idx      = '0;
                            d.cnt      = '0;
                        end else begin
                            d.err = 1'b1;
                        end
                    end
                end
                ST_SETUP: begin
                    d.clr   = 1'b1;
                    d.cnt   = '0;
                    d.state = ST_CLR_HI;
                end
                ST_CLR_HI: begin
                    if (q.cnt == CLR_LAST) begin
                        d.cnt   = '0;
                        d.clr   = 1'b0;
                        d.state = ST_CLR_LO;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_CLR_LO: begin
                    if (q.cnt == CLR_LAST) begin
                        d.cnt   = '0;
                        d.state = ST_WRITE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_WRITE: begin
                    wr_go   = 1'b1;
                    d.state = ST_WAIT;
                end
                ST_WAIT: begin
                    if (wr_done) begin
                        if (q.idx == WR_LAST) begin
                            d.state = ST_IDLE;
                            d.busy  = 1'b0;
                            d.done  = 1'b1;
                        end else begin
                            d.idx   = q.idx + 3'd1;
                            d.state = ST_WRITE;
                        end
                    end
                end
                default: d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o       = q.busy;
    assign done_o       = q.done;
    assign error_o      = q.err;
    assign lane_en_o    = q.lane_en;
    assign turn_dis_o   = q.turn_dis;
    assign tp_clr_o     = q.clr;
    assign force_rx_o   = '0;
    assign force_stop_o = '0;
    assign turn_req_o   = '0;

endmodule

// File: rtl/rxseq_checker.sv
module rxseq_checker
    import rxseq_pkg::*;
#(
    parameter int NLANES = 4,
    parameter int RATE_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              stop_i,
    input logic [RATE_W-1:0] rate_mbps_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              error_o,
    input logic [NLANES-1:0] lane_en_o,
    input logic [NLANES-1:0] force_rx_o,
    input logic [NLANES-1:0] force_stop_o,
    input logic [NLANES-1:0] turn_req_o,
    input logic [NLANES-1:0] turn_dis_o,
    input logic              tp_clk_o,
    input logic              tp_clr_o,
    input logic              tp_en_o
);

    p_fields_r1: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (force_rx_o == '0 && force_stop_o == '0 &&
                    turn_req_o == '0 && (&turn_dis_o)));

    p_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (lane_en_o != '0 &&
                    ((lane_en_o & (lane_en_o + 1'b1)) & {NLANES{1'b1}}) == '0));

    p_clr_after_clk_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tp_clr_o |-> tp_clk_o);

    p_en_at_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tp_clk_o) |-> tp_en_o);

    p_bad_rate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !stop_i && 32'(rate_mbps_i) > 32'(MAX_RATE))
        |=> (error_o && !busy_o));

    p_done_alone_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !error_o));

    p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (!busy_o && lane_en_o == '0 && !tp_clr_o));

    p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !stop_i) |=> !error_o);

endmodule

bind rxphy_bringup_seq rxseq_checker #(.NLANES(NLANES), .RATE_W(RATE_W)) u_chk (.*);

// File: tb/rxphy_bringup_seq_tb_top.sv
`timescale 1ns/1ps
module rxphy_bringup_seq_tb_top;

    localparam int NL = 4;
    localparam int RW = 11;
    localparam int CW = 12;
    localparam int SH = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          stop = 1'b0;
    logic [2:0]    lane_cnt = '0;
    logic [RW-1:0] rate = '0;
    logic          busy, done, error;
    logic [NL-1:0] lane_en, force_rx, force_stop, turn_req, turn_dis;
    logic          tp_clk, tp_clr, tp_en;
    logic [7:0]    tp_din;

    rxphy_bringup_seq #(.NLANES(NL), .RATE_W(RW), .CLR_WAIT(CW), .STEP_HOLD(SH)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .stop_i(stop),
        .lane_cnt_i(lane_cnt), .rate_mbps_i(rate),
        .busy_o(busy), .done_o(done), .error_o(error), .lane_en_o(lane_en),
        .force_rx_o(force_rx), .force_stop_o(force_stop), .turn_req_o(turn_req),
        .turn_dis_o(turn_dis), .tp_clk_o(tp_clk), .tp_clr_o(tp_clr),
        .tp_en_o(tp_en), .tp_din_o(tp_din)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    int bound_tab [39] = '{89, 99, 109, 129, 139, 149, 169, 179, 199, 219, 239, 249, 269,
                           299, 329, 359, 399, 449, 499, 549, 599, 649, 699, 749, 799, 849,
                           899, 949, 999, 1049, 1099, 1149, 1199, 1249, 1299, 1349, 1399,
                           1449, 1500};
    int code_tab [39]  = '{'h00, 'h10, 'h20, 'h01, 'h11, 'h21, 'h02, 'h12, 'h22, 'h03,
                           'h13, 'h23, 'h04, 'h14, 'h05, 'h15, 'h25, 'h06, 'h16, 'h07,
                           'h17, 'h08, 'h18, 'h09, 'h19, 'h29, 'h39, 'h0a, 'h1a, 'h2a,
                           'h3a, 'h0b, 'h1b, 'h2b, 'h3b, 'h0c, 'h1c, 'h2c, 'h3c};
    int addr_tab [7]   = '{'h34, 'h44, 'h54, 'h84, 'h94, 'h75, 'h00};

    function automatic int exp_range(input int r);
        for (int i = 0; i < 39; i++)
            if (r <= bound_tab[i]) return code_tab[i];
        return -1;
    endfunction

    function automatic int exp_value(input int i, input int rc);
        if (i >= 1 && i <= 4) return rc * 2;
        if (i == 5) return 4;
        return 0;
    endfunction

    function automatic int exp_mask(input int l);
        return (1 << l) - 1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Waveform monitor: rebuilds writes from test-port edges, sampled at negedge.
    int  cyc = 0;
    bit  prev_clk = 0, prev_clr = 0, pend = 0, clk_at_clr = 0;
    int  fall_cyc = 0, fall_addr = 0, clr_rise_cyc = 0, clr_fall_cyc = -1;
    int  nwr = 0, clr_dur = -1, first_gap = -1, en_bad = 0, gap_bad = 0, nclr_rise = 0;
    int  wr_a [16];
    int  wr_v [16];

    always @(negedge clk) begin
        cyc++;
        if (tp_clk && !prev_clk && pend) begin
            if (nwr < 16) begin
                wr_a[nwr] = fall_addr;
                wr_v[nwr] = int'(tp_din);
            end
            if (cyc - fall_cyc != 3 * SH) gap_bad++;
            nwr++;
            pend = 0;
        end
        if (!tp_clk && prev_clk) begin
            pend      = 1;
            fall_cyc  = cyc;
            fall_addr = int'(tp_din);
            if (!tp_en) en_bad++;
            if (nwr == 0 && clr_fall_cyc >= 0 && first_gap < 0) first_gap = cyc - clr_fall_cyc;
        end
        if (tp_clr && !prev_clr) begin
            nclr_rise++;
            clk_at_clr   = tp_clk;
            clr_rise_cyc = cyc;
        end
        if (!tp_clr && prev_clr) begin
            clr_dur      = cyc - clr_rise_cyc;
            clr_fall_cyc = cyc;
        end
        prev_clk = tp_clk;
        prev_clr = tp_clr;
        if (cyc >= 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic mon_clear();
        nwr = 0; pend = 0; clr_dur = -1; clr_fall_cyc = -1; first_gap = -1;
        en_bad = 0; gap_bad = 0; nclr_rise = 0; clk_at_clr = 0;
    endtask

    task automatic pulse_start(input int l, input int r);
        @(negedge clk);
        start    = 1'b1;
        lane_cnt = 3'(l);
        rate     = RW'(r);
        @(negedge clk);
        start    = 1'b0;
    endtask

    task automatic run_ok(input int l, input int r, input bit interfere);
        int rc;
        int t;
        bit got;
        rc = exp_range(r);
        mon_clear();
        pulse_start(l, r);
        chk(busy == 1'b1, "R1 busy", int'(busy), 1);
        chk(force_rx == '0 && force_stop == '0 && turn_req == '0, "R1 forces",
            int'({force_rx, force_stop, turn_req}), 0);
        chk(turn_dis == 4'hF, "R1 turn_dis", int'(turn_dis), 15);
        chk(int'(lane_en) == exp_mask(l), "R2 lane_en", int'(lane_en), exp_mask(l));
        if (interfere) begin
            repeat (10) @(negedge clk);
            pulse_start((l == 4) ? 1 : 4, 2000);
            chk(error == 1'b0, "R10 no error", int'(error), 0);
            chk(int'(lane_en) == exp_mask(l) && busy, "R10 mask kept", int'(lane_en), exp_mask(l));
        end
        got = 0;
        t = 0;
        while (t < 3000 && !got) begin
            @(negedge clk);
            t++;
            if (done) got = 1;
        end
        chk(got, "R8 done seen", int'(got), 1);
        chk(!busy, "R8 busy low with done", int'(busy), 0);
        chk(nwr == 7, "R5 write count", nwr, 7);
        for (int i = 0; i < 7; i++) begin
            chk(wr_a[i] == addr_tab[i], "R5 address", wr_a[i], addr_tab[i]);
            chk(wr_v[i] == exp_value(i, rc), "R6 value", wr_v[i], exp_value(i, rc));
        end
        chk(clk_at_clr, "R3 clock high before clear", int'(clk_at_clr), 1);
        chk(clr_dur == CW, "R3 clear length", clr_dur, CW);
        chk(first_gap == CW + 1 + 2 * SH, "R3 post-clear wait", first_gap, CW + 1 + 2 * SH);
        chk(en_bad == 0, "R4 enable at fall", en_bad, 0);
        chk(gap_bad == 0, "R4 fall-to-rise", gap_bad, 0);
        @(negedge clk);
        chk(!done, "R8 single pulse", int'(done), 0);
    endtask

    task automatic run_bad(input int l, input int r);
        int prior;
        prior = int'(lane_en);
        mon_clear();
        pulse_start(l, r);
        chk(error == 1'b1, "R7 error pulse", int'(error), 1);
        chk(busy == 1'b0, "R7 busy stays low", int'(busy), 0);
        repeat (40) @(negedge clk);
        chk(nwr == 0 && nclr_rise == 0, "R7 no programming", nwr + nclr_rise, 0);
        chk(int'(lane_en) == prior, "R7 lane_en kept", int'(lane_en), prior);
    endtask

    task automatic run_stop();
        int n0;
        bit saw_done;
        mon_clear();
        pulse_start(3, 700);
        repeat (40) @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk(!busy, "R9 busy cleared", int'(busy), 0);
        chk(lane_en == '0, "R9 lanes off", int'(lane_en), 0);
        chk(!tp_clr, "R9 clear low", int'(tp_clr), 0);
        n0 = nwr;
        saw_done = 0;
        repeat (200) begin
            @(negedge clk);
            if (done) saw_done = 1;
        end
        chk(!saw_done, "R9 no done", int'(saw_done), 0);
        chk(nwr == n0, "R9 no more writes", nwr, n0);
    endtask

    initial begin
        void'($urandom(32'd20240517));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !error, "R11 status", int'({busy, done, error}), 0);
        chk(lane_en == '0 && turn_dis == '0, "R11 controls", int'({lane_en, turn_dis}), 0);
        chk(!tp_clk && !tp_clr && !tp_en && tp_din == '0, "R11 test port",
            int'({tp_clk, tp_clr, tp_en, tp_din}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_ok(1, 89, 0);
        run_ok(4, 1500, 0);
        run_ok(2, 99, 0);
        run_ok(3, 129, 0);
        run_ok(2, 500, 1);
        run_bad(4, 1501);
        run_bad(2, 2047);
        run_bad(0, 300);
        run_bad(5, 300);
        run_stop();
        run_ok(3, 90, 0);

        for (int k = 0; k < 8; k++) begin
            int l;
            int r;
            l = 1 + int'($urandom % 4);
            r = int'($urandom % 1700);
            if (exp_range(r) >= 0) run_ok(l, r, 0);
            else                   run_bad(l, r);
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule